// File: doc/BRIEF.md
# Indirect Masked Byte Register Port

This block puts one 32-bit command/status word in front of an internal file of 8-bit registers. A host writes a single word that carries a start flag, an operation selector, a 14-bit register address, an 8-bit bit mask and an 8-bit data byte. The port accepts the word, stays busy for a fixed number of internal cycles, and then performs either a plain read or a masked read-modify-write on the addressed byte.

The host polls the top bit of the same word until it clears. The low byte then holds the result. After a read, the result is the stored byte. After a write, the result is the byte's new value, so the host can compare it with the data it meant to store. Commands that arrive while an operation is still running are dropped.

The internal file holds `DEPTH` bytes, a power of two up to 16K. Address bits above the index width are carried in the status word but do not select a different byte.

Top module: `ind_reg_port`

## Requirements
- R1: After reset, `host_rdata` reads all zeros and every register byte holds 0x00.
- R2: A host word is a command only when `host_wr` is high and bit 31 is 1. Bit 30 selects the operation: 1 is a write and 0 is a read. Bits [29:16] hold the address, [15:8] the mask and [7:0] the data. A host word with bit 31 at 0 changes nothing at the port.
- R3: Bit 31 of `host_rdata` (busy) rises in the cycle after a command is accepted. It stays high for exactly `LATENCY` cycles, where `LATENCY` is 1 to 8, and then falls.
- R4: A write stores `(old & ~mask) | (data & mask)`. Bits whose mask bit is 0 keep their previous value.
- R5: When a write completes, bits [7:0] of `host_rdata` show the byte's new value.
- R6: When a read completes, bits [7:0] show the stored byte. The stored contents do not change.
- R7: A command presented while busy is high is ignored. Busy and the latched command fields are unaffected, and the command's target byte is not modified.
- R8: Bit 30 shows the operation, bits [29:16] the address and bits [15:8] the mask of the last accepted command. They hold their values until the next command is accepted.
- R9: Only the low log2(`DEPTH`) address bits select a byte. Addresses that differ only above those bits reach the same byte.
- R10: While an operation is in progress, bits [7:0] keep the result of the previous operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the command word |
| host_wdata | input | 32 | Command word |
| host_rdata | output | 32 | Status word: busy, operation, address, mask and result byte |

## Verification
The bench builds the port with `LATENCY` = 5 and `DEPTH` = 32. With a multi-cycle latency, the bench can place a second command in the middle of a busy window and poll across several cycles. The small depth lets random addresses with set upper bits alias onto bytes that are already written, which exercises the address truncation. Random masks, including all-zero and all-ones masks, cover both the pure-read-back case and the full-overwrite case of the merge.

// File: rtl/ind_reg_pkg.sv
package ind_reg_pkg;
    localparam int ADDR_W = 14;
    localparam int BYTE_W = 8;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    typedef struct packed {
        logic              start;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] mask;
        logic [BYTE_W-1:0] data;
    } cmd_t;
endpackage

// File: rtl/ind_cmd_decode.sv
module ind_cmd_decode
    import ind_reg_pkg::*;
(
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    input  logic        busy,
    output logic        accept,
    output cmd_t        cmd
);
    always_comb begin
        cmd    = cmd_t'(host_wdata);
        accept = host_wr && cmd.start && !busy;
    end
endmodule

// File: rtl/ind_byte_merge.sv
module ind_byte_merge #(
    parameter int W = 8
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] data,
    output logic [W-1:0] merged
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign merged[b] = mask[b] ? data[b] : old_val[b];
    end
endmodule

// File: rtl/ind_regfile.sv
module ind_regfile #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (we && (idx == IDX_W'(i))) begin
                mem_q[i] <= wdata;
            end
        end
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/ind_reg_port.sv
module ind_reg_port
    import ind_reg_pkg::*;
#(
    parameter int LATENCY = 3,
    parameter int DEPTH   = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = 3;
    localparam logic [CNT_W-1:0] LAT_M1 = CNT_W'(LATENCY - 1);

    typedef struct packed {
        logic              busy;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] mask;
        logic [BYTE_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] result;
    } state_t;

    state_t s_d, s_q;
    logic        accept;
    cmd_t        cmd;
    logic        rf_we;
    logic [BYTE_W-1:0] rf_rdata;
    logic [BYTE_W-1:0] merged;

    ind_cmd_decode u_dec (
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .busy       (s_q.busy),
        .accept     (accept),
        .cmd        (cmd)
    );

    ind_regfile #(.DEPTH(DEPTH), .W(BYTE_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .idx   (s_q.addr[IDX_W-1:0]),
        .wdata (merged),
        .rdata (rf_rdata)
    );

    ind_byte_merge #(.W(BYTE_W)) u_merge (
        .old_val (rf_rdata),
        .mask    (s_q.mask),
        .data    (s_q.data),
        .merged  (merged)
    );

    always_comb begin
        s_d   = s_q;
        rf_we = 1'b0;
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy   = 1'b0;
                s_d.result = s_q.is_wr ? merged : rf_rdata;
                rf_we      = s_q.is_wr;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (accept) begin
            s_d.busy  = 1'b1;
            s_d.is_wr = (cmd.op == OP_WRITE);
            s_d.addr  = cmd.addr;
            s_d.mask  = cmd.mask;
            s_d.data  = cmd.data;
            s_d.cnt   = LAT_M1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign host_rdata = {s_q.busy, s_q.is_wr, s_q.addr, s_q.mask, s_q.result};
endmodule

// File: rtl/ind_reg_port_chk.sv
module ind_reg_port_chk #(
    parameter int LATENCY = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic [31:0] host_wdata,
    input logic [31:0] host_rdata
);
    logic [3:0] busy_cnt_q;
    logic [7:0] acc_data_q;
    logic       acc_go;

    assign acc_go = host_wr && host_wdata[31] && !host_rdata[31];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt_q <= '0;
            acc_data_q <= '0;
        end else begin
            busy_cnt_q <= host_rdata[31] ? busy_cnt_q + 1'b1 : 4'd0;
            if (acc_go) acc_data_q <= host_wdata[7:0];
        end
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |=> host_rdata[31]); // R3

    AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rdata[31] && !(host_wr && host_wdata[31])) |=> !host_rdata[31]); // R2

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_rdata[31]) |-> (busy_cnt_q == 4'(LATENCY))); // R3

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[31] |=> $stable(host_rdata[30:8])); // R7

    AST_WRITE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(host_rdata[31]) && host_rdata[30])
        |-> (((host_rdata[7:0] ^ acc_data_q) & host_rdata[15:8]) == 8'h00)); // R5

    AST_RESULT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_rdata[31]) |-> $stable(host_rdata[7:0])); // R10
endmodule

bind ind_reg_port ind_reg_port_chk #(.LATENCY(LATENCY)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
);

// File: tb/ind_reg_port_tb_top.sv
`timescale 1ns/1ps
module ind_reg_port_tb_top;
    localparam int LAT   = 5;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] mdl [DEPTH];

    always #2 clk = ~clk;

    ind_reg_port #(.LATENCY(LAT), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    function automatic logic [7:0] exp_merge(logic [7:0] o, logic [7:0] m, logic [7:0] d);
        return (o & ~m) | (d & m);
    endfunction

    function automatic logic [31:0] mk(logic wr, logic [13:0] a, logic [7:0] m, logic [7:0] d);
        return {1'b1, wr, a, m, d};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Issue one command, poll busy, return result byte and busy length
    task automatic run_cmd(logic [31:0] w, output logic [7:0] res, output int lat);
        @(negedge clk);
        host_wr = 1'b1; host_wdata = w;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
        lat = 0;
        while (host_rdata[31] && lat < 20) begin
            lat++;
            @(negedge clk);
        end
        res = host_rdata[7:0];
    endtask

    task automatic do_write(logic [13:0] a, logic [7:0] m, logic [7:0] d);
        logic [7:0] r; int l; logic [7:0] e;
        e = exp_merge(mdl[a % DEPTH], m, d);
        run_cmd(mk(1'b1, a, m, d), r, l);
        mdl[a % DEPTH] = e;
        chk(r == e, "R4/R5 write echo", {24'h0, r}, {24'h0, e});
        chk(l == LAT, "R3 busy length", l, LAT);
        chk(host_rdata[30:8] == {1'b1, a, m}, "R8 fields", host_rdata[30:8], {1'b1, a, m});
    endtask

    task automatic do_read(logic [13:0] a);
        logic [7:0] r; int l;
        run_cmd(mk(1'b0, a, 8'h00, 8'h00), r, l);
        chk(r == mdl[a % DEPTH], "R6 read value", {24'h0, r}, {24'h0, mdl[a % DEPTH]});
        chk(l == LAT, "R3 busy length", l, LAT);
    endtask

    initial begin
        #400000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] r; int l;
        logic [31:0] snap;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_rdata == 32'h0, "R1 reset state", host_rdata, 32'h0);

        do_read(14'd7);                       // R1 untouched byte is zero
        do_write(14'd3, 8'hFF, 8'hA5);        // R4 full overwrite
        do_write(14'd3, 8'h0F, 8'h3C);        // R4 partial mask
        do_write(14'd3, 8'h00, 8'hFF);        // R4 zero mask keeps old
        do_read(14'd3);                       // R6

        // R10: result byte held through a busy window
        @(negedge clk);
        snap = host_rdata;
        host_wr = 1'b1; host_wdata = mk(1'b1, 14'd9, 8'hFF, 8'h11);
        @(negedge clk);
        host_wr = 1'b0;
        chk(host_rdata[7:0] == snap[7:0], "R10 result held", host_rdata[7:0], snap[7:0]);
        chk(host_rdata[31], "R3 busy rises", host_rdata[31], 1);
        // R7: second command mid-busy
        host_wr = 1'b1; host_wdata = mk(1'b1, 14'd10, 8'hFF, 8'h77);
        @(negedge clk);
        host_wr = 1'b0;
        l = 2;
        while (host_rdata[31] && l < 20) begin
            chk(host_rdata[29:16] == 14'd9, "R7 address kept", host_rdata[29:16], 9);
            l++;
            @(negedge clk);
        end
        chk(l - 1 == LAT, "R7 busy length unchanged", l - 1, LAT);
        mdl[9] = 8'h11;
        @(negedge clk);
        chk(!host_rdata[31], "R7 no extra op", host_rdata[31], 0);
        do_read(14'd10);                      // R7 target untouched

        // R2: word without start bit
        snap = host_rdata;
        @(negedge clk);
        host_wr = 1'b1; host_wdata = {1'b0, 1'b1, 14'd4, 8'hFF, 8'h99};
        @(negedge clk);
        host_wr = 1'b0;
        @(negedge clk);
        chk(host_rdata == snap, "R2 no start ignored", host_rdata, snap);
        do_read(14'd4);

        // R9: aliasing above index width
        do_write(14'd5 + 14'(DEPTH), 8'hFF, 8'hC3);
        do_read(14'd5);
        do_write(14'h3FE0 | 14'd5, 8'hF0, 8'h0F);
        do_read(14'd5);

        // Random mix
        for (int i = 0; i < 200; i++) begin
            logic [13:0] a;
            a = 14'($urandom);
            if ($urandom % 2) do_write(a, 8'($urandom), 8'($urandom));
            else do_read(a);
        end
        finish_run();
    end
endmodule